// File: doc/BRIEF.md
# Stereo Volume Stage with Raised-Cosine Soft Mute

This block scales a stereo stream of signed samples on its way to a playback converter. A 6-bit volume code picks a gain from a table. The table has 1 dB steps over most of its range, coarser steps near the bottom and full silence at the end. That gain is multiplied by a ramp factor. The ramp factor follows a raised-cosine curve between silence and unity, so that muting, un-muting and converter power changes never cause a sudden jump at the output. The left and right channels always receive the same combined gain.

Samples enter and leave over valid/ready handshakes. An input sample is accepted in a cycle where `in_valid` and `in_ready` are both high. The scaled pair appears on the output register one cycle later and stays there until the consumer takes it with `out_ready`. The input reports ready only when the output register is empty or is being emptied in that same cycle, so back-pressure passes straight through with no extra buffering. The control pins `vol_code`, `mute_req` and `power_en` are plain levels. They are sampled together with each accepted sample, and only an accepted sample moves the ramp.

The ramp position runs from 0 (silent) to 1024 (unity). A mute request moves it by 1 per sample. A power transition moves it by 8 per sample. Whenever the target changes, the position turns around from wherever it stands.

Top module: `vmute_gain`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. Each accepted input produces exactly one output pair in the next cycle, in order. While `out_valid` is high and `out_ready` is low, the outputs hold their values.
- R2: Volume codes 0 and 1 give unity volume gain, which is 32768 in unsigned Q1.15. At full ramp, the output equals the input.
- R3: Codes 2 to 51 attenuate by (code − 1) dB. The gain for A dB is g(A), where g(0)=32768 and g(n+1)=floor(g(n)·29205/32768).
- R4: Codes 52, 53, 54, 55 and 56 use g(52), g(54), g(57), g(60) and g(66). Codes 57 to 63 give a volume gain of 0, so both outputs are 0.
- R5: The ramp position p lies in the range 0 to 1024. The ramp factor is C[p>>5], where C[k]=round(32768·(1−cos(πk/32))/2) for k<32 and C[32]=32768. With power on and mute requested, p falls by 1 per accepted sample, so the 1025th sample after a mute request from unity is 0.
- R6: A step is fast (8) in any of three cases: `power_en` is low; `power_en` was low at the previous accepted sample; or a power-up ramp has not yet reached 1024 and no mute was requested on the way. Otherwise the step is 1. The position saturates at 0 and at 1024, so a power-down from unity reaches silence on the 129th sample.
- R7: When mute is released partway through a ramp, p rises again from its current value. It does not jump.
- R8: The position changes only on accepted samples. Control changes made while no sample is accepted have no effect until the next accepted sample.
- R9: The combined gain is e=floor(vol·ramp/32768). Each output is floor(sample·e/32768), saturated to the signed sample width. Left and right use the same e.
- R10: After reset, p=0, `out_valid`=0, the previous power state reads as off, and the outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample pair is valid |
| in_ready | output | 1 | Block can take an input pair |
| in_left | input | DW | Left input sample, signed |
| in_right | input | DW | Right input sample, signed |
| vol_code | input | CODE_W | Volume code |
| mute_req | input | 1 | Soft mute request |
| power_en | input | 1 | Converter power enable |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Consumer takes the output pair |
| out_left | output | DW | Left scaled sample, signed |
| out_right | output | DW | Right scaled sample, signed |

## Verification
The assertions rely on three things about the inputs:
- The producer holds its sample pair steady while waiting.
- Control levels count only at accepted samples.
- The consumer may stall the output for any number of cycles.

The stimulus drives every input just after a rising edge, which keeps these assumptions true. It holds `in_valid` and the data until the design accepts them. A separate process throttles `out_ready` at random, so stalls land both during ramps and during steady volume.

// File: rtl/vmute_pkg.sv
`timescale 1ns/1ps
package vmute_pkg;
  localparam int          GAIN_FRAC     = 15;
  localparam int          GAIN_W        = GAIN_FRAC + 2;
  localparam int unsigned UNITY_I       = 32'd1 << GAIN_FRAC;
  localparam int unsigned DB_STEP_MUL   = 29205;
  localparam int unsigned ATT_SILENT    = 255;
  localparam int          VOL_MUTE_CODE = 57;
  localparam int          COS_PTS       = 32;

  typedef logic [GAIN_W-1:0] gain_t;

  function automatic int unsigned code_to_atten(input int unsigned code);
    if (code <= 1)  return 0;
    if (code <= 51) return code - 1;
    case (code)
      52:      return 52;
      53:      return 54;
      54:      return 57;
      55:      return 60;
      56:      return 66;
      default: return ATT_SILENT;
    endcase
  endfunction

  function automatic gain_t atten_to_gain(input int unsigned db);
    longint unsigned g;
    g = longint'(UNITY_I);
    if (db == ATT_SILENT) return '0;
    for (int i = 0; i < int'(db); i++) begin
      g = (g * longint'(DB_STEP_MUL)) >> GAIN_FRAC;
    end
    return gain_t'(g);
  endfunction

  function automatic gain_t cos_point(input int unsigned k);
    int unsigned m;
    int unsigned v;
    if (k >= COS_PTS) return gain_t'(UNITY_I);
    m = (k <= COS_PTS / 2) ? k : COS_PTS - k;
    case (m)
      0:       v = 0;
      1:       v = 79;
      2:       v = 315;
      3:       v = 705;
      4:       v = 1247;
      5:       v = 1935;
      6:       v = 2761;
      7:       v = 3719;
      8:       v = 4799;
      9:       v = 5990;
      10:      v = 7282;
      11:      v = 8661;
      12:      v = 10114;
      13:      v = 11628;
      14:      v = 13188;
      15:      v = 14778;
      16:      v = 16384;
      default: v = 0;
    endcase
    if (k <= COS_PTS / 2) return gain_t'(v);
    return gain_t'(UNITY_I - v);
  endfunction
endpackage

// File: rtl/vmute_vol_lut.sv
`timescale 1ns/1ps
module vmute_vol_lut
  import vmute_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output gain_t             gain
);
  localparam int N_CODES = 1 << CODE_W;

  gain_t lut [N_CODES];

  for (genvar c = 0; c < N_CODES; c++) begin : g_lut
    assign lut[c] = atten_to_gain(code_to_atten(c));
  end

  assign gain = lut[code];
endmodule

// File: rtl/vmute_ramp.sv
`timescale 1ns/1ps
module vmute_ramp
  import vmute_pkg::*;
#(
  parameter int RAMP_LEN = 1024,
  parameter int PWR_LEN  = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  mute_req,
  input  logic  power_en,
  output gain_t ramp_gain
);
  localparam int FULL      = RAMP_LEN;
  localparam int POS_W     = $clog2(RAMP_LEN + 1);
  localparam int FAST_STEP = RAMP_LEN / PWR_LEN;
  localparam int SHIFT     = $clog2(RAMP_LEN / COS_PTS);
  localparam int IDX_W     = $clog2(COS_PTS + 1);
  localparam int N_IDX     = 1 << IDX_W;

  logic [POS_W-1:0] pos_q, pos_d, step;
  logic             pwr_q, up_fast_q, up_fast_d;
  logic             fast, go_down;
  logic [IDX_W-1:0] idx;
  gain_t            cos_lut [N_IDX];

  for (genvar k = 0; k < N_IDX; k++) begin : g_cos
    assign cos_lut[k] = cos_point(k);
  end

  always_comb begin
    go_down = mute_req || !power_en;
    fast    = !power_en || up_fast_q || (power_en && !pwr_q);
    step    = fast ? POS_W'(FAST_STEP) : POS_W'(1);
    if (go_down) begin
      pos_d = (pos_q > step) ? pos_q - step : '0;
    end else begin
      pos_d = ((POS_W'(FULL) - pos_q) <= step) ? POS_W'(FULL) : pos_q + step;
    end
    up_fast_d = fast && power_en && !mute_req && (pos_d != POS_W'(FULL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      pwr_q     <= 1'b0;
      up_fast_q <= 1'b0;
    end else if (adv) begin
      pos_q     <= pos_d;
      pwr_q     <= power_en;
      up_fast_q <= up_fast_d;
    end
  end

  assign idx       = IDX_W'(pos_q >> SHIFT);
  assign ramp_gain = cos_lut[idx];

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(FULL)) else $error("ramp position out of range"); // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos_q)) else $error("ramp moved without a sample"); // R8
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pos_q <= $past(pos_q) + FAST_STEP) && ($past(pos_q) <= pos_q + FAST_STEP))
    else $error("ramp jumped"); // R7
  AST_SILENT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    adv && mute_req && pos_q == '0 |=> pos_q == '0) else $error("ramp left silence under mute"); // R5
endmodule

// File: rtl/vmute_scale.sv
`timescale 1ns/1ps
module vmute_scale
  import vmute_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] sample,
  input  gain_t                eff,
  output logic signed [DW-1:0] scaled
);
  localparam int PW = DW + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] s_ext, g_ext, prod, shifted;

  always_comb begin
    s_ext   = PW'(sample);
    g_ext   = $signed({{(PW-GAIN_W){1'b0}}, eff});
    prod    = s_ext * g_ext;
    shifted = prod >>> GAIN_FRAC;
    if (shifted > MAXV)      scaled = MAXV[DW-1:0];
    else if (shifted < MINV) scaled = MINV[DW-1:0];
    else                     scaled = shifted[DW-1:0];
  end
endmodule

// File: rtl/vmute_gain.sv
`timescale 1ns/1ps
module vmute_gain
  import vmute_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CODE_W   = 6,
  parameter int RAMP_LEN = 1024,
  parameter int PWR_LEN  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic [CODE_W-1:0] vol_code,
  input  logic              mute_req,
  input  logic              power_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right
);
  localparam int MIX_W = 2 * GAIN_W;

  logic               accept;
  gain_t              vol_gain, ramp_gain, eff;
  logic [MIX_W-1:0]   mix;
  logic signed [DW-1:0] sc_left, sc_right;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vmute_vol_lut #(.CODE_W(CODE_W)) u_vol (
    .code (vol_code),
    .gain (vol_gain)
  );

  vmute_ramp #(.RAMP_LEN(RAMP_LEN), .PWR_LEN(PWR_LEN)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (accept),
    .mute_req  (mute_req),
    .power_en  (power_en),
    .ramp_gain (ramp_gain)
  );

  always_comb begin
    mix = vol_gain * ramp_gain;
    eff = GAIN_W'(mix >> GAIN_FRAC);
  end

  vmute_scale #(.DW(DW)) u_scale_l (.sample(in_left),  .eff(eff), .scaled(sc_left));
  vmute_scale #(.DW(DW)) u_scale_r (.sample(in_right), .eff(eff), .scaled(sc_right));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= sc_left;
      out_right <= sc_right;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right))
    else $error("output changed while stalled"); // R1
  AST_MUTE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    accept && int'(vol_code) >= VOL_MUTE_CODE |=> out_left == '0 && out_right == '0)
    else $error("mute code let signal through"); // R4
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && vol_code <= CODE_W'(1) && ramp_gain == gain_t'(UNITY_I)
      |=> out_left == $past(in_left) && out_right == $past(in_right))
    else $error("unity gain altered sample"); // R2
  AST_SAME_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_left == in_right |=> out_left == out_right)
    else $error("channels scaled differently"); // R9
endmodule

// File: tb/vmute_gain_bench.sv
`timescale 1ns/1ps
module vmute_gain_bench;
  localparam int DW = 16;
  localparam int SEED = 32'h5a17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_left = '0, in_right = '0;
  logic [5:0] vol_code = '0;
  logic mute_req = 1'b0, power_en = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [DW-1:0] out_left, out_right;

  always #2.5 clk = ~clk;

  vmute_gain u_vmute_gain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .vol_code(vol_code),
    .mute_req(mute_req), .power_en(power_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, bp_on = 0;
  string cur_tag = "R10";
  int vol_tab [64];
  int m_pos = 0, m_pwr = 0, m_upf = 0;
  int q_l[$], q_r[$], q_tol[$];
  string q_tag[$];

  function automatic int atten_of(int code);
    if (code <= 1) return 0;
    if (code <= 51) return code - 1;
    case (code)
      52: return 52; 53: return 54; 54: return 57; 55: return 60; 56: return 66;
      default: return -1;
    endcase
  endfunction

  function automatic int cos_ref(int k);
    real v;
    if (k >= 32) return 32768;
    v = 32768.0 * (1.0 - $cos(3.14159265358979 * k / 32.0)) / 2.0;
    return $rtoi(v + 0.5);
  endfunction

  task automatic chk(string tag, int act, int exp, int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 ready", int'(in_ready), int'(!out_valid || out_ready), 0);
      if (out_valid && out_ready) begin
        if (q_l.size() == 0) chk("R1 extra output", 1, 0, 0);
        else begin
          chk(q_tag[0], int'(out_left),  q_l[0], q_tol[0]);
          chk(q_tag[0], int'(out_right), q_r[0], q_tol[0]);
          void'(q_l.pop_front()); void'(q_r.pop_front());
          void'(q_tol.pop_front()); void'(q_tag.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        int idx, rg, eff, st, fast;
        longint pl, pr;
        idx = m_pos >> 5;
        rg  = cos_ref(idx);
        eff = (vol_tab[vol_code] * rg) >>> 15;
        pl  = (longint'(in_left)  * eff) >>> 15;
        pr  = (longint'(in_right) * eff) >>> 15;
        q_l.push_back(int'(pl)); q_r.push_back(int'(pr));
        q_tol.push_back((idx != 0 && idx != 32) ? 1 : 0);
        q_tag.push_back(cur_tag);
        fast = (!power_en || m_upf != 0 || (power_en && m_pwr == 0)) ? 1 : 0;
        st = fast ? 8 : 1;
        if (mute_req || !power_en) m_pos = (m_pos > st) ? m_pos - st : 0;
        else m_pos = (1024 - m_pos <= st) ? 1024 : m_pos + st;
        m_upf = (fast != 0 && power_en && !mute_req && m_pos != 1024) ? 1 : 0;
        m_pwr = power_en ? 1 : 0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  task automatic send(int l, int r);
    in_valid = 1'b1; in_left = DW'(l); in_right = DW'(r);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic int rnd_s();
    return int'($urandom % 65536) - 32768;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(SEED));
    for (int c = 0; c < 64; c++) begin
      int a, g;
      a = atten_of(c);
      if (a < 0) g = 0;
      else begin
        g = 32768;
        for (int i = 0; i < a; i++) g = (g * 29205) >>> 15;
      end
      vol_tab[c] = g;
    end
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", int'(out_valid), 0, 0);
    chk("R10 out_left in reset", int'(out_left), 0, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 in_ready after reset", int'(in_ready), 1, 0);

    // R10/R6: first sample after reset is silent; power-up ramp of 128 samples
    power_en = 1'b1;
    send(30000, 30000);
    cur_tag = "R6 power-up";
    for (int i = 0; i < 140; i++) send(rnd_s(), rnd_s());

    // R2 extremes at full ramp
    cur_tag = "R2 unity";
    send(32767, -32768); send(-1, 1);
    vol_code = 6'd1; send(12345, -12345);

    // R3/R4 sweep over all codes, with back-pressure
    bp_on = 1;
    for (int c = 0; c < 64; c++) begin
      vol_code = 6'(c);
      cur_tag = (c <= 1) ? "R2 code" : (c <= 51) ? "R3 code" : "R4 code";
      send(32767, -32768); send(rnd_s(), rnd_s());
    end

    // R9 equal channels, random volumes
    cur_tag = "R9 same gain";
    for (int i = 0; i < 40; i++) begin
      int s;
      s = rnd_s();
      vol_code = 6'($urandom % 64);
      send(s, s);
    end

    // R5 full soft mute from unity
    vol_code = 6'd0; cur_tag = "R5 mute ramp";
    mute_req = 1'b1;
    for (int i = 0; i < 1030; i++) send(20000, -20000);

    // R7 release partway and reverse
    cur_tag = "R7 reverse";
    mute_req = 1'b0;
    for (int i = 0; i < 300; i++) send(rnd_s(), rnd_s());
    mute_req = 1'b1;
    for (int i = 0; i < 100; i++) send(rnd_s(), rnd_s());
    mute_req = 1'b0;
    for (int i = 0; i < 1100; i++) send(25000, -25000);

    // R8 control changes without samples do not move the ramp
    cur_tag = "R8 no strobe";
    mute_req = 1'b1;
    repeat (200) @(posedge clk);
    #1; mute_req = 1'b0;
    send(32000, -32000); send(rnd_s(), rnd_s());

    // R6 power-down then power-up
    cur_tag = "R6 power-down";
    power_en = 1'b0;
    for (int i = 0; i < 135; i++) send(rnd_s(), rnd_s());
    cur_tag = "R6 power-up again";
    power_en = 1'b1;
    for (int i = 0; i < 135; i++) send(rnd_s(), rnd_s());

    // R9 random mix of controls
    cur_tag = "R9 random";
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 50 == 0)  vol_code = 6'($urandom % 64);
      if ($urandom % 200 == 0) mute_req = ~mute_req;
      if ($urandom % 300 == 0) power_en = ~power_en;
      send(rnd_s(), rnd_s());
    end

    bp_on = 0;
    repeat (2000) begin
      if (q_l.size() == 0) break;
      @(negedge clk);
    end
    chk("R1 outputs drained", q_l.size(), 0, 0);
    finish_run();
  end
endmodule